// File: doc/BRIEF.md
# Prescaled Line-Interval Interrupt Timer

This block generates a periodic interrupt request for a cartridge-side processor bus. Instead of watching video fetches, it counts processor clock-enable cycles and derives one "line" every 114 enabled cycles. Each line advances an 8-bit up-counter. When the counter steps past its top value, the block raises a level interrupt and starts again from a programmable start value.

Software sets up the block with single-byte writes to three fixed addresses. Two addresses each load one 4-bit half of the start value (the reload value). The third address holds a 2-bit mode. Bit 1 of the mode runs the timer. Bit 0 is a re-arm flag, and it becomes the new run bit each time the counter wraps. Any write to the mode address also acknowledges the interrupt. The interrupt output is registered and stays high until that acknowledge.

Top module: `sl_irq_timer`

## Requirements
- R1: After synchronous reset, `irq` is 0, the timer is stopped, and the reload value and counter are 0.
- R2: A write to address 0xF000 loads bits 3:0 of the reload value from `wr_data[3:0]`. A write to 0xF004 loads bits 7:4 of the reload value from `wr_data[3:0]`. `wr_data[7:4]` is ignored in both cases.
- R3: A write to 0xF008 stores `wr_data[1:0]` as the mode, where bit 1 = run and bit 0 = re-arm. If `wr_data[1]` is 1, the same write loads the counter from the reload value and zeroes the prescaler.
- R4: Every write to 0xF008 clears `irq` on the following cycle. This write takes priority over a counter wrap that falls in the same cycle: that wrap neither raises `irq` nor reloads the counter.
- R5: The prescaler advances only on cycles with `cpu_ce` high while run is set. It does not advance on the cycle of a mode write. It produces one line tick on every 114th such cycle. While stopped, it holds its value.
- R6: A line tick increments the counter by one. A tick at 0xFF instead reloads the counter from the reload value, sets `irq`, and copies re-arm into run. As a result, `irq` first rises on the (256 − reload)×114-th advancing cycle after the starting mode write.
- R7: Once set, `irq` stays high until the next write to 0xF008, even while counting continues.
- R8: Writes to any other address change neither `irq` nor the timing.
- R9: Changing the reload value while the timer runs does not disturb the counter that is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | Processor cycle enable, one pulse per bus cycle |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Registered, active-high interrupt request |

## Verification
The critical coincidence is a mode write that lands in the same cycle as the counter wrap. The bench starts the timer with reload 0xFF, counts exactly 113 advancing cycles, and issues the mode write on the 114th. With a stop value, `irq` must never rise. With a run value, the next rise must come a full 114 advancing cycles after that write, which proves the write restarted the prescaler and suppressed the wrap. A scoreboard holds the expected rise positions, counted in enabled cycles, and matches each observed rising edge against them.

// File: rtl/slirq_pkg.sv
package slirq_pkg;

  typedef struct packed {
    logic run;
    logic rearm;
  } slirq_mode_t;

  localparam int unsigned MODE_W = 2;

  localparam logic [15:0] DEF_LO_ADDR   = 16'hF000;
  localparam logic [15:0] DEF_HI_ADDR   = 16'hF004;
  localparam logic [15:0] DEF_MODE_ADDR = 16'hF008;

endpackage

// File: rtl/slirq_decode.sv
module slirq_decode
  import slirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR   = DEF_LO_ADDR,
  parameter logic [ADDR_W-1:0] HI_ADDR   = DEF_HI_ADDR,
  parameter logic [ADDR_W-1:0] MODE_ADDR = DEF_MODE_ADDR,
  localparam int unsigned RLD_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RLD_W-1:0]  reload,
  output logic              mode_we,
  output slirq_mode_t       mode_wdata
);

  logic lo_we, hi_we;
  logic unused_data_hi;

  assign lo_we      = wr_en && (wr_addr == LO_ADDR);
  assign hi_we      = wr_en && (wr_addr == HI_ADDR);
  assign mode_we    = wr_en && (wr_addr == MODE_ADDR);
  assign mode_wdata = slirq_mode_t'(wr_data[MODE_W-1:0]);
  assign unused_data_hi = ^wr_data[DATA_W-1:NIB_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
    end else begin
      if (lo_we) reload[NIB_W-1:0]     <= wr_data[NIB_W-1:0];
      if (hi_we) reload[RLD_W-1:NIB_W] <= wr_data[NIB_W-1:0];
    end
  end

  // R2
  lo_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> reload[NIB_W-1:0] == $past(wr_data[NIB_W-1:0]));

  // R2
  hi_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> reload[RLD_W-1:NIB_W] == $past(wr_data[NIB_W-1:0]));

endmodule

// File: rtl/slirq_prescale.sv
module slirq_prescale #(
  parameter int unsigned STEP = 114,
  localparam int unsigned DIV_W = (STEP > 1) ? $clog2(STEP) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic run,
  output logic tick
);

  localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = adv && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (adv) begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_q <= LAST);

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(div_q));

  // R3
  div_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> div_q == '0);

endmodule

// File: rtl/slirq_count.sv
module slirq_count
  import slirq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  slirq_mode_t      mode_wdata,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  output slirq_mode_t      mode,
  output logic             irq
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mode  <= '0;
      irq   <= 1'b0;
    end else if (mode_we) begin
      mode <= mode_wdata;
      irq  <= 1'b0;
      if (mode_wdata.run) cnt_q <= reload;
    end else if (tick) begin
      if (cnt_q == TOP) begin
        cnt_q    <= reload;
        irq      <= 1'b1;
        mode.run <= mode.rearm;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_wdata.run) |=> cnt_q == $past(reload));

  // R4
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> !irq);

  // R6
  rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tick && cnt_q == TOP && !mode_we));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !mode_we && cnt_q != TOP) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !mode_we && cnt_q == TOP) |=> (irq && mode.run == $past(mode.rearm) && cnt_q == $past(reload)));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !mode_we) |=> irq);

endmodule

// File: rtl/sl_irq_timer.sv
module sl_irq_timer
  import slirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned STEP   = 114,
  parameter logic [ADDR_W-1:0] LO_ADDR   = DEF_LO_ADDR,
  parameter logic [ADDR_W-1:0] HI_ADDR   = DEF_HI_ADDR,
  parameter logic [ADDR_W-1:0] MODE_ADDR = DEF_MODE_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);

  localparam int unsigned CNT_W = 2 * NIB_W;

  logic [CNT_W-1:0] reload;
  logic             mode_we;
  slirq_mode_t      mode_wdata;
  slirq_mode_t      mode;
  logic             tick;
  logic             adv;
  logic             clr;

  assign adv = mode.run && cpu_ce && !mode_we;
  assign clr = mode_we && mode_wdata.run;

  slirq_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload(reload), .mode_we(mode_we), .mode_wdata(mode_wdata)
  );

  slirq_prescale #(.STEP(STEP)) u_prescale (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .run(mode.run), .tick(tick)
  );

  slirq_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .reload(reload), .tick(tick), .mode(mode), .irq(irq)
  );

  // R4
  top_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == MODE_ADDR) |=> !irq);

  // R8
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != MODE_ADDR && irq) |=> irq);

  // R1
  reset_chk: assert property (@(posedge clk) rst |=> !irq);

endmodule

// File: tb/sl_irq_timer_tb.sv
module sl_irq_timer_tb;

  localparam int STEP = 114;
  localparam logic [15:0] A_LO   = 16'hF000;
  localparam logic [15:0] A_HI   = 16'hF004;
  localparam logic [15:0] A_MODE = 16'hF008;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_ce = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  int ce_cnt = 0;
  int ce_div = 1;
  int ce_ph  = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  sl_irq_timer u_dut (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic bit next_ce();
    bit c;
    c = (ce_ph == 0);
    ce_ph = (ce_ph + 1) % ce_div;
    return c;
  endfunction

  task automatic step();
    @(negedge clk);
    wr_en  = 1'b0;
    cpu_ce = next_ce();
    if (cpu_ce) ce_cnt++;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    cpu_ce  = next_ce();
    if (a == A_MODE) ce_cnt = 0;
    else if (cpu_ce) ce_cnt++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_irq(input int lim);
    int n = 0;
    while (!irq && n < lim) begin
      step();
      n++;
    end
  endtask

  task automatic run_to_ce(input int target);
    while (ce_cnt < target) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: matches each irq rising edge against the next expected position
  initial begin
    bit prev = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (rst) prev = 1'b0;
      else begin
        if (irq && !prev) begin
          if (exp_q.size() == 0) chk("R4/R5/R8 unexpected irq rise", 1, 0);
          else chk("R6 rise position", ce_cnt, exp_q.pop_front());
        end
        prev = irq;
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    steps(3);
    @(negedge clk); rst = 1'b0;
    // R1: idle after reset, nothing counts with cpu_ce running
    chk("R1 irq after reset", irq, 0);
    steps(300);
    chk("R1 no irq while stopped", irq, 0);

    // R2 R3 R6: reload 0xF0 assembled from nibbles, upper data bits ignored
    wr(A_HI, 8'h0F); wr(A_LO, 8'h30);
    wr(A_MODE, 8'h02);
    exp_q.push_back((256 - 'hF0) * STEP);
    wait_irq(4000);
    chk("R6 irq after 16 lines", irq, 1);
    // R7 sticky, and R8 other address does not acknowledge
    wr(16'hF00A, 8'h00); wr(16'hF009, 8'h03);
    steps(200);
    chk("R7/R8 irq held", irq, 1);
    // R4 acknowledge
    wr(A_MODE, 8'h00); step();
    chk("R4 irq cleared by mode write", irq, 0);

    // R2 R5 R9: reload 0xFE via 0xAE/0x5F, cpu_ce every other cycle
    ce_div = 2; ce_ph = 0;
    wr(A_LO, 8'hAE); wr(A_HI, 8'h5F);
    wr(A_MODE, 8'h03);
    exp_q.push_back((256 - 'hFE) * STEP);
    run_to_ce(50);
    wr(A_LO, 8'h0F); // R9 reload change mid-run
    wait_irq(1000);
    chk("R5/R9 irq with half-rate enable", irq, 1);
    steps(600);
    chk("R7 irq held across further wraps", irq, 1);
    wr(A_MODE, 8'h00); step();
    chk("R4 acknowledge", irq, 0);

    // R5: one-in-three enable, reload now 0xFF
    ce_div = 3; ce_ph = 0;
    wr(A_MODE, 8'h02);
    exp_q.push_back(STEP);
    wait_irq(1000);
    chk("R5 irq with third-rate enable", irq, 1);
    wr(A_MODE, 8'h00); step();
    chk("R4 acknowledge", irq, 0);

    // R3 restart zeroes prescaler
    ce_div = 1; ce_ph = 0;
    wr(A_MODE, 8'h02);
    run_to_ce(100);
    wr(A_MODE, 8'h02);
    exp_q.push_back(STEP);
    wait_irq(400);
    chk("R3 restart realigns prescaler", irq, 1);
    wr(A_MODE, 8'h00); step();

    // R4 collision: stop write on the wrapping cycle suppresses irq
    wr(A_MODE, 8'h02);
    run_to_ce(STEP - 1);
    wr(A_MODE, 8'h00);
    steps(400);
    chk("R4 wrap suppressed by stop write", irq, 0);

    // R4 collision: run write on the wrapping cycle restarts a full line
    wr(A_MODE, 8'h02);
    run_to_ce(STEP - 1);
    wr(A_MODE, 8'h02);
    exp_q.push_back(STEP);
    steps(2);
    chk("R4 no irq on colliding run write", irq, 0);
    wait_irq(400);
    chk("R4 irq one line after colliding write", irq, 1);
    wr(A_MODE, 8'h00); step();

    // R8: unrelated addresses do not start the timer
    wr(16'hF00C, 8'h03); wr(16'hF001, 8'h03); wr(16'hE008, 8'h02);
    steps(400);
    chk("R8 other addresses inert", irq, 0);

    steps(4);
    chk("R6 all expected rises seen", exp_q.size(), 0);
    finish_run();
  end

endmodule